// File: doc/BRIEF.md
# Write-Triggered Serial Shift Register

This block is a parallel/serial converter driven by an external serial clock. A CPU-side write places a byte in the shift register. If the interface enable input is high and no transfer is running, the write also starts a transfer of DATA_W bits. During the transfer the byte leaves most significant bit first, and the incoming bits are collected into the same register. When the last bit has been sampled, a one-cycle completion pulse appears and the received byte sits on the parallel read port.

Two line arrangements are supported. In split mode the outgoing bit goes to a push-pull serial output and the incoming bit comes from a separate serial input. In shared mode one open-drain data line carries both directions. The block pulls the line low for a 0 bit and releases it for a 1 bit. The sampled bit is the AND of the line and the block's own bit. A device that only receives on the shared line must therefore load all ones before the transfer. A separate busy-signalling flag can be set by bus-side logic while its enable is high, and any write to the register clears it.

Top module: `ssr_serial_shift`

## Requirements
- R1: After reset, rd_data is 0, xfer_active, done and collision are 0, so_out is 1, line_drive_low is 0 and bus_busy is 0.
- R2: A write while en is 0 loads wr_data into rd_data on the next cycle and starts no transfer: xfer_active stays 0, and done never pulses even when sck toggles.
- R3: A write while en is 1 and no transfer is running loads the byte and sets xfer_active on the next cycle. In split mode so_out shows bit DATA_W-1 of the written byte.
- R4: The outgoing bits leave MSB first. The next bit appears on a falling sck edge, so after k rising edges the output carries bit DATA_W-1-k of the written byte.
- R5: The incoming bit is sampled on each rising sck edge and shifted in at the LSB. After DATA_W rising edges, rd_data holds the incoming bits with the first sampled bit at bit DATA_W-1.
- R6: In the clock cycle after the DATA_W-th rising sck edge, done is 1 for exactly one cycle and xfer_active is 0.
- R7: A write while xfer_active is 1 is ignored: the transfer and its received byte are unaffected, and collision is 1 for one cycle.
- R8: With line_shared=1 (shared mode), so_out is held at 1, line_drive_low is the inverse of the current outgoing bit, and the sampled bit is line_in AND the outgoing bit. With line_shared=0, line_drive_low is 0 and the sampled bit is si_in.
- R9: In shared mode, a byte of all ones keeps line_drive_low at 0 for the whole transfer, and rd_data ends equal to the bits on line_in.
- R10: bus_busy becomes 1 the cycle after busy_set while busy_en is 1 and stays 0 while busy_en is 0. A write clears the flag the next cycle, including when busy_set is also high, and busy_en keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Interface enable; a write starts a transfer only when high |
| line_shared | input | 1 | 0: split serial pins, 1: shared open-drain line |
| wr_en | input | 1 | CPU write strobe for the shift register |
| wr_data | input | DATA_W | CPU write data |
| rd_data | output | DATA_W | Parallel read of the shift register |
| sck_in | input | 1 | Serial clock, idle high |
| si_in | input | 1 | Serial input in split mode |
| so_out | output | 1 | Serial output in split mode, held at 1 in shared mode |
| line_in | input | 1 | Sampled level of the shared data line |
| line_drive_low | output | 1 | Pulls the shared line low when 1 |
| xfer_active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | One-cycle pulse on a write during a transfer |
| busy_en | input | 1 | Busy-signalling enable |
| busy_set | input | 1 | Bus-side request to raise the busy flag |
| bus_busy | output | 1 | Busy flag, gated by busy_en |

## Verification
The bench builds the block with the default DATA_W of 8. With that width, a full transfer needs only 16 serial clock phases, so every bit position can be compared one by one against the written and driven bytes. The chosen bytes put alternating patterns, all ones and all zeros on both the transmit and receive sides. A shared-mode run with a byte other than all ones shows the wired-AND effect on the received byte, and a collision write is injected in the middle of a transfer.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int unsigned DATA_W_DEF = 8;

    typedef enum logic {
        LINE_SPLIT  = 1'b0,
        LINE_SHARED = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    function automatic logic pick_in_bit(line_mode_e mode, logic si, logic line, logic own);
        return (mode == LINE_SHARED) ? (line & own) : si;
    endfunction

endpackage

// File: rtl/ssr_sck_edge.sv
module ssr_sck_edge
    import ssr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck_in,
    output sck_evt_t evt
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b1;
        else     sck_q <= sck_in;
    end

    always_comb begin
        evt.rise = sck_in & ~sck_q;
        evt.fall = ~sck_in & sck_q;
    end
endmodule

// File: rtl/ssr_shift_core.sv
module ssr_shift_core
    import ssr_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  line_mode_e        mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  sck_evt_t          evt,
    input  logic              si_in,
    input  logic              line_in,
    output logic [DATA_W-1:0] shreg,
    output logic              tx_bit,
    output logic              active,
    output logic              done,
    output logic              collision
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt;
    logic             in_bit;

    always_comb in_bit = pick_in_bit(mode, si_in, line_in, tx_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            tx_bit    <= 1'b1;
            active    <= 1'b0;
            cnt       <= '0;
            done      <= 1'b0;
            collision <= 1'b0;
        end else begin
            done      <= 1'b0;
            collision <= wr_en & active;
            if (wr_en && !active) begin
                shreg  <= wr_data;
                tx_bit <= wr_data[DATA_W-1];
                cnt    <= '0;
                active <= en;
            end else if (active) begin
                if (evt.rise) begin
                    shreg <= {shreg[DATA_W-2:0], in_bit};
                    if (cnt == LAST) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (evt.fall) begin
                    tx_bit <= shreg[DATA_W-1];
                end
            end
        end
    end
endmodule

// File: rtl/ssr_busy_track.sv
module ssr_busy_track (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic busy_en,
    input  logic busy_set,
    output logic bus_busy
);
    logic flag;

    always_ff @(posedge clk) begin
        if (rst)                      flag <= 1'b0;
        else if (wr_en)               flag <= 1'b0;
        else if (busy_set && busy_en) flag <= 1'b1;
    end

    always_comb bus_busy = flag & busy_en;
endmodule

// File: rtl/ssr_serial_shift.sv
module ssr_serial_shift
    import ssr_pkg::*;
#(
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              line_shared,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sck_in,
    input  logic              si_in,
    output logic              so_out,
    input  logic              line_in,
    output logic              line_drive_low,
    output logic              xfer_active,
    output logic              done,
    output logic              collision,
    input  logic              busy_en,
    input  logic              busy_set,
    output logic              bus_busy
);
    sck_evt_t   evt;
    line_mode_e mode;
    logic       tx_bit;

    always_comb mode = line_shared ? LINE_SHARED : LINE_SPLIT;

    ssr_sck_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck_in (sck_in),
        .evt    (evt)
    );

    ssr_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .evt       (evt),
        .si_in     (si_in),
        .line_in   (line_in),
        .shreg     (rd_data),
        .tx_bit    (tx_bit),
        .active    (xfer_active),
        .done      (done),
        .collision (collision)
    );

    ssr_busy_track u_busy (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .busy_en  (busy_en),
        .busy_set (busy_set),
        .bus_busy (bus_busy)
    );

    always_comb begin
        so_out         = (mode == LINE_SHARED) ? 1'b1 : tx_bit;
        line_drive_low = (mode == LINE_SHARED) & ~tx_bit;
    end
endmodule

// File: rtl/ssr_serial_shift_chk.sv
module ssr_serial_shift_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              line_shared,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              so_out,
    input logic              line_drive_low,
    input logic              xfer_active,
    input logic              done,
    input logic              collision,
    input logic              bus_busy
);
    AST_IDLE_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !xfer_active) |=> rd_data == $past(wr_data)); // R2
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !en && !xfer_active) |=> !xfer_active); // R2
    AST_ENABLED_START: assert property (@(posedge clk) disable iff (rst)
        (wr_en && en && !xfer_active) |=> xfer_active); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !xfer_active); // R6
    AST_COLLISION_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && xfer_active) |=> collision); // R7
    AST_SPLIT_NO_PULL: assert property (@(posedge clk) disable iff (rst)
        !line_shared |-> !line_drive_low); // R8
    AST_SHARED_SO_HIGH: assert property (@(posedge clk) disable iff (rst)
        line_shared |-> so_out); // R8
    AST_WRITE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !bus_busy); // R10
endmodule

bind ssr_serial_shift ssr_serial_shift_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .en             (en),
    .line_shared    (line_shared),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .so_out         (so_out),
    .line_drive_low (line_drive_low),
    .xfer_active    (xfer_active),
    .done           (done),
    .collision      (collision),
    .bus_busy       (bus_busy)
);

// File: tb/ssr_serial_shift_tb.sv
module ssr_serial_shift_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         line_shared = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         sck_in = 1'b1;
    logic         si_in = 1'b0;
    logic         so_out;
    logic         ext_drv = 1'b1;
    logic         line_in;
    logic         line_drive_low;
    logic         xfer_active;
    logic         done;
    logic         collision;
    logic         busy_en = 1'b0;
    logic         busy_set = 1'b0;
    logic         bus_busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign line_in = ext_drv & ~line_drive_low;

    ssr_serial_shift #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .line_shared(line_shared),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sck_in(sck_in), .si_in(si_in), .so_out(so_out),
        .line_in(line_in), .line_drive_low(line_drive_low),
        .xfer_active(xfer_active), .done(done), .collision(collision),
        .busy_en(busy_en), .busy_set(busy_set), .bus_busy(bus_busy)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [W-1:0] d);
        @(negedge clk);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Runs W serial clock periods. rx is what the far end presents, MSB first.
    task automatic run_bits(input logic [W-1:0] tx, input logic [W-1:0] rx,
                            input logic shared, input bit inject_coll);
        logic [W-1:0] exp_rx;
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            sck_in = 1'b0;
            @(negedge clk);
            if (!shared) begin
                chk(so_out == tx[i], "R4 split output bit", so_out, tx[i]);
            end else begin
                chk(line_drive_low == ~tx[i], "R8 shared pull", line_drive_low, ~tx[i]);
                chk(so_out == 1'b1, "R8 so held high", so_out, 1);
            end
            si_in   = rx[i];
            ext_drv = rx[i];
            sck_in  = 1'b1;
            if (inject_coll && i == 4) begin
                wr_data = 8'h00;
                wr_en   = 1'b1;
            end
            @(negedge clk);
            if (inject_coll && i == 4) begin
                wr_en = 1'b0;
                chk(collision == 1'b1, "R7 collision pulse", collision, 1);
                chk(xfer_active == 1'b1, "R7 transfer continues", xfer_active, 1);
            end
            if (i > 0) chk(done == 1'b0, "R6 no early done", done, 0);
        end
        exp_rx = shared ? (rx & tx) : rx;
        chk(done == 1'b1, "R6 done after last rise", done, 1);
        chk(xfer_active == 1'b0, "R6 idle at done", xfer_active, 0);
        chk(rd_data == exp_rx, "R5 received byte", rd_data, exp_rx);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        chk(collision == 1'b0, "R7 collision one cycle", collision, 0);
    endtask

    task automatic t_reset();
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
        chk(xfer_active == 1'b0, "R1 xfer_active", xfer_active, 0);
        chk(done == 1'b0 && collision == 1'b0, "R1 pulses", {done, collision}, 0);
        chk(so_out == 1'b1, "R1 so_out", so_out, 1);
        chk(line_drive_low == 1'b0, "R1 line_drive_low", line_drive_low, 0);
        chk(bus_busy == 1'b0, "R1 bus_busy", bus_busy, 0);
    endtask

    task automatic t_disabled_write();
        bit saw_done = 0;
        en = 1'b0;
        cpu_write(8'hC3);
        chk(rd_data == 8'hC3, "R2 load while disabled", rd_data, 8'hC3);
        chk(xfer_active == 1'b0, "R2 no start", xfer_active, 0);
        for (int k = 0; k < 2 * W; k++) begin
            @(negedge clk);
            sck_in = ~sck_in;
            @(negedge clk);
            if (done) saw_done = 1;
        end
        sck_in = 1'b1;
        chk(!saw_done, "R2 no done while disabled", saw_done, 0);
        chk(rd_data == 8'hC3, "R2 value kept", rd_data, 8'hC3);
    endtask

    task automatic t_split(input logic [W-1:0] tx, input logic [W-1:0] rx, input bit coll);
        en = 1'b1;
        line_shared = 1'b0;
        cpu_write(tx);
        chk(xfer_active == 1'b1, "R3 start on enabled write", xfer_active, 1);
        chk(so_out == tx[W-1], "R3 msb presented", so_out, tx[W-1]);
        run_bits(tx, rx, 1'b0, coll);
    endtask

    task automatic t_shared(input logic [W-1:0] tx, input logic [W-1:0] rx);
        bit pulled;
        en = 1'b1;
        line_shared = 1'b1;
        cpu_write(tx);
        chk(xfer_active == 1'b1, "R3 start shared", xfer_active, 1);
        run_bits(tx, rx, 1'b1, 1'b0);
        if (tx == '1) begin
            pulled = line_drive_low;
            chk(!pulled, "R9 never pulls with all ones", pulled, 0);
            chk(rd_data == rx, "R9 received equals line", rd_data, rx);
        end
        line_shared = 1'b0;
        ext_drv = 1'b1;
    endtask

    task automatic t_busy();
        en = 1'b0;
        @(negedge clk);
        busy_en = 1'b0; busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk(bus_busy == 1'b0, "R10 no set while disabled", bus_busy, 0);
        busy_en = 1'b1; busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk(bus_busy == 1'b1, "R10 set", bus_busy, 1);
        cpu_write(8'h11);
        chk(bus_busy == 1'b0, "R10 write clears", bus_busy, 0);
        chk(busy_en == 1'b1, "R10 enable kept", busy_en, 1);
        @(negedge clk);
        busy_set = 1'b1; wr_data = 8'h22; wr_en = 1'b1;
        @(negedge clk);
        busy_set = 1'b0; wr_en = 1'b0;
        chk(bus_busy == 1'b0, "R10 write beats set", bus_busy, 0);
        busy_set = 1'b1;
        @(negedge clk);
        busy_set = 1'b0;
        chk(bus_busy == 1'b1, "R10 set again", bus_busy, 1);
        busy_en = 1'b0;
        #1;
        chk(bus_busy == 1'b0, "R10 gated by enable", bus_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled_write();
        t_split(8'hA5, 8'h3C, 1'b0);
        t_split(8'h00, 8'hFF, 1'b0);
        t_split(8'hFF, 8'h00, 1'b1);
        t_shared(8'h5A, 8'hF0);
        t_shared(8'hFF, 8'h96);
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule